// File: doc/BRIEF.md
# Banked GPIO Register and Interrupt Unit

This block is a memory-mapped controller for up to eight banks of 32 general-purpose pins. A 32-bit register bus with a write strobe reaches per-bank state (output levels, the sampled input levels, interrupt status and interrupt mask) and a small control word for every pin. The control word selects the pin's direction and its interrupt trigger. Read data is returned in the same cycle as the address. Writes take effect at the next clock edge.

Output levels and mask bits change only through ports where a 1 sets a bit or a 1 clears it. Interrupt status is cleared by writing a 1. Interrupts are captured on edges only, and each bank drives its own interrupt line. Pad drivers, input synchronisation and debounce timing sit in other blocks. An external per-pin lock vector, driven by those blocks or by a security unit, protects pins from write access.

Top module: `gpio_bank_unit`

## Requirements
- R1: Pin n belongs to bank n>>5 at bit n&31. Each per-bank register lies at its base plus 4 times the bank number: output levels 0x000, input levels 0x020, set port 0x040, clear port 0x060, interrupt status 0x080, mask 0x0A0, mask-clear port 0x0C0.
- R2: Writing a 1 to a bit of the set port drives that pin's output high, and writing a 1 to the clear port drives it low. Zero bits leave the output unchanged. The output-level register reads back the state, and `pin_out` shows it.
- R3: The control word for pin n is at 0x100 + 4*n. Bit 0 selects the direction (1 = input, 0 = output), and `pin_oe` is the inverse of that bit. A read returns bit 0 and bits 4:3, with every other bit zero.
- R4: A read of the input-level register returns the bank's slice of `pin_in` in the same cycle.
- R5: Control bits 4:3 select the trigger: 1 = rising, 2 = falling, 3 = both edges, 0 = no capture. An edge is a difference between `pin_in` at one clock edge and at the edge before, and it sets the status bit at the later edge.
- R6: Writing a 1 to an interrupt status bit clears it, unless an edge is captured for that bit in the same cycle, in which case the bit stays set.
- R7: Writing a 1 to a mask bit at 0x0A0 sets that bit. Writing a 1 at 0x0C0 clears it. The mask reads back at 0x0A0.
- R8: `bank_irq[b]` is high exactly while some bit of bank b's status AND NOT mask is set.
- R9: While `pin_lock[n]` is high, set-port and clear-port bits for pin n and writes to pin n's control word have no effect.
- R10: After reset, every pin is an input with trigger 0, every output is low, every mask bit is set and every status bit is clear.
- R11: Reads of unmapped offsets return zero. This covers offsets with nonzero low two bits, offset 0x0E0 onward below 0x100, banks not present, and offsets past the last control word. The set, clear and mask-clear ports also read as zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the current address |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| pin_in | input | 32*NUM_BANKS | Synchronised pin levels |
| pin_lock | input | 32*NUM_BANKS | Per-pin write protection |
| pin_out | output | 32*NUM_BANKS | Output levels |
| pin_oe | output | 32*NUM_BANKS | Output enables, high for output pins |
| bank_irq | output | NUM_BANKS | Per-bank interrupt lines |

## Verification
Read data and the input-level register depend only on the current address and pins, so they are due in the same cycle. Writes, captured edges and status clears appear after exactly one clock edge. `bank_irq`, `pin_out` and `pin_oe` follow registered state and so move in the cycle after the edge that updates it. The bench drives every input on the falling edge and compares all outputs 1 ns later against a reference model. It then advances that model only at the rising edge, using the inputs that were present at that edge, so each expected value matches the cycle in which the result is due.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PINS_PER_BANK = 32;
    localparam int BIT_W         = 5;
    localparam int MAX_BANKS     = 8;
    localparam int BANK_IDX_W    = 3;
    localparam int PIN_IDX_W     = BANK_IDX_W + BIT_W;

    // Register kind, taken from offset bits 7:5 below the control area
    typedef enum logic [2:0] {
        RG_OUT_LVL = 3'd0,
        RG_IN_LVL  = 3'd1,
        RG_OUT_SET = 3'd2,
        RG_OUT_CLR = 3'd3,
        RG_INT_STS = 3'd4,
        RG_INT_MSK = 3'd5,
        RG_MSK_CLR = 3'd6,
        RG_NONE    = 3'd7
    } bank_reg_e;

    typedef struct packed {
        logic [PINS_PER_BANK-1:0]       out;
        logic [PINS_PER_BANK-1:0]       sts;
        logic [PINS_PER_BANK-1:0]       msk;
        logic [PINS_PER_BANK-1:0]       dir;
        logic [PINS_PER_BANK-1:0]       prev;
        logic [PINS_PER_BANK-1:0][1:0]  trig;
    } bank_state_t;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit_bank,
    output logic                  hit_ctl,
    output bank_reg_e             kind,
    output logic [BANK_IDX_W-1:0] bank_idx,
    output logic [PIN_IDX_W-1:0]  pin_idx
);
    localparam int NPINS = NUM_BANKS * PINS_PER_BANK;
    localparam logic [ADDR_W-1:0] CTL_BASE = ADDR_W'('h100);
    localparam logic [ADDR_W-1:0] CTL_END  = ADDR_W'('h100 + 4 * NPINS);

    always_comb begin
        hit_bank = 1'b0;
        hit_ctl  = 1'b0;
        kind     = bank_reg_e'(addr[7:5]);
        bank_idx = addr[4:2];
        pin_idx  = PIN_IDX_W'((addr - CTL_BASE) >> 2);
        if (addr[1:0] == 2'b00) begin
            if (addr < CTL_BASE) begin
                hit_bank = (kind != RG_NONE) && (int'(bank_idx) < NUM_BANKS);
            end else if (addr < CTL_END) begin
                hit_ctl = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
    import gpio_bank_pkg::*;
(
    input  logic [PINS_PER_BANK-1:0]      pin_now,
    input  logic [PINS_PER_BANK-1:0]      pin_prev,
    input  logic [PINS_PER_BANK-1:0][1:0] trig,
    output logic [PINS_PER_BANK-1:0]      hit,
    output logic [PINS_PER_BANK-1:0]      off
);
    logic [PINS_PER_BANK-1:0] rise;
    logic [PINS_PER_BANK-1:0] fall;

    assign rise = pin_now & ~pin_prev;
    assign fall = ~pin_now & pin_prev;

    // trigger bit 0 arms rising capture, bit 1 arms falling capture
    for (genvar i = 0; i < PINS_PER_BANK; i++) begin : g_pin
        assign hit[i] = (trig[i][0] & rise[i]) | (trig[i][1] & fall[i]);
        assign off[i] = (trig[i] == 2'b00);
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bank_we,
    input  bank_reg_e                     reg_kind,
    input  logic                          ctl_we,
    input  logic [BIT_W-1:0]              ctl_bit,
    input  logic [31:0]                   wdata,
    input  logic [PINS_PER_BANK-1:0]      lock,
    input  logic [PINS_PER_BANK-1:0]      pin_now,
    output logic [PINS_PER_BANK-1:0]      out_q,
    output logic [PINS_PER_BANK-1:0]      sts_q,
    output logic [PINS_PER_BANK-1:0]      msk_q,
    output logic [PINS_PER_BANK-1:0]      dir_q,
    output logic [PINS_PER_BANK-1:0][1:0] trig_q,
    output logic                          irq
);
    bank_state_t st_d, st_q;
    logic [PINS_PER_BANK-1:0] hit;
    logic [PINS_PER_BANK-1:0] off;
    logic [PINS_PER_BANK-1:0] sts_clr_d;
    logic [PINS_PER_BANK-1:0] wr_free_d;

    gpio_edge_det u_edge (
        .pin_now  (pin_now),
        .pin_prev (st_q.prev),
        .trig     (st_q.trig),
        .hit      (hit),
        .off      (off)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_now;
        wr_free_d = wdata & ~lock;
        sts_clr_d = '0;
        if (bank_we) begin
            case (reg_kind)
                RG_OUT_SET: st_d.out = st_q.out | wr_free_d;
                RG_OUT_CLR: st_d.out = st_q.out & ~wr_free_d;
                RG_INT_STS: sts_clr_d = wdata;
                RG_INT_MSK: st_d.msk = st_q.msk | wdata;
                RG_MSK_CLR: st_d.msk = st_q.msk & ~wdata;
                default:    ;
            endcase
        end
        // a captured edge outranks a clear in the same cycle
        st_d.sts = (st_q.sts & ~sts_clr_d) | hit;
        if (ctl_we && !lock[ctl_bit]) begin
            st_d.dir[ctl_bit]  = wdata[0];
            st_d.trig[ctl_bit] = wdata[4:3];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{out: '0, sts: '0, msk: '1, dir: '1, prev: '0, trig: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_q  = st_q.out;
    assign sts_q  = st_q.sts;
    assign msk_q  = st_q.msk;
    assign dir_q  = st_q.dir;
    assign trig_q = st_q.trig;
    assign irq    = |(st_q.sts & ~st_q.msk);

    // R2: set-port bits on unlocked pins show up one edge later
    p_out_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we && reg_kind == RG_OUT_SET
        |=> (out_q & $past(wdata & ~lock)) == $past(wdata & ~lock));

    // R9: locked pins keep their output through set or clear writes
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we && (reg_kind == RG_OUT_SET || reg_kind == RG_OUT_CLR)
        |=> ((out_q ^ $past(out_q)) & $past(lock)) == '0);

    // R7: mask-clear port clears the written bits
    p_msk_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we && reg_kind == RG_MSK_CLR
        |=> (msk_q & $past(wdata)) == '0);

    // R8: a fully masked bank keeps its line low
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&msk_q) |-> !irq);

    // R6: a captured edge always leaves the status bit set
    p_edge_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (~sts_q & $past(hit)) == '0);

    // R5: pins with trigger 0 never raise a status bit
    p_trig_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sts_q & ~$past(sts_q) & $past(off)) == '0);
endmodule

// File: rtl/gpio_bank_unit.sv
module gpio_bank_unit
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 12,
    localparam int NPINS    = NUM_BANKS * PINS_PER_BANK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  pin_lock,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NUM_BANKS-1:0] bank_irq
);
    logic                  hit_bank;
    logic                  hit_ctl;
    bank_reg_e             kind;
    logic [BANK_IDX_W-1:0] bank_idx;
    logic [PIN_IDX_W-1:0]  pin_idx;

    logic [PINS_PER_BANK-1:0]      out_v  [NUM_BANKS];
    logic [PINS_PER_BANK-1:0]      sts_v  [NUM_BANKS];
    logic [PINS_PER_BANK-1:0]      msk_v  [NUM_BANKS];
    logic [PINS_PER_BANK-1:0]      dir_v  [NUM_BANKS];
    logic [PINS_PER_BANK-1:0][1:0] trig_v [NUM_BANKS];

    gpio_addr_dec #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr     (reg_addr),
        .hit_bank (hit_bank),
        .hit_ctl  (hit_ctl),
        .kind     (kind),
        .bank_idx (bank_idx),
        .pin_idx  (pin_idx)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic we_b;
        logic cw_b;
        assign we_b = reg_we && hit_bank && (bank_idx == BANK_IDX_W'(b));
        assign cw_b = reg_we && hit_ctl && (pin_idx[BIT_W +: BANK_IDX_W] == BANK_IDX_W'(b));

        gpio_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .bank_we  (we_b),
            .reg_kind (kind),
            .ctl_we   (cw_b),
            .ctl_bit  (pin_idx[BIT_W-1:0]),
            .wdata    (reg_wdata),
            .lock     (pin_lock[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pin_now  (pin_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .out_q    (out_v[b]),
            .sts_q    (sts_v[b]),
            .msk_q    (msk_v[b]),
            .dir_q    (dir_v[b]),
            .trig_q   (trig_v[b]),
            .irq      (bank_irq[b])
        );

        assign pin_out[b*PINS_PER_BANK +: PINS_PER_BANK] = out_v[b];
        assign pin_oe[b*PINS_PER_BANK +: PINS_PER_BANK]  = ~dir_v[b];
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_bank && bank_idx == BANK_IDX_W'(b)) begin
                case (kind)
                    RG_OUT_LVL: reg_rdata = out_v[b];
                    RG_IN_LVL:  reg_rdata = pin_in[b*PINS_PER_BANK +: PINS_PER_BANK];
                    RG_INT_STS: reg_rdata = sts_v[b];
                    RG_INT_MSK: reg_rdata = msk_v[b];
                    default:    reg_rdata = '0;
                endcase
            end
            if (hit_ctl && pin_idx[BIT_W +: BANK_IDX_W] == BANK_IDX_W'(b)) begin
                reg_rdata = {27'b0, trig_v[b][pin_idx[BIT_W-1:0]], 2'b00,
                             dir_v[b][pin_idx[BIT_W-1:0]]};
            end
        end
    end

    // R11: unmapped offsets read zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_bank || hit_ctl) |-> reg_rdata == '0);

    // R11: write-only ports read zero
    p_wo_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_bank && (kind == RG_OUT_SET || kind == RG_OUT_CLR || kind == RG_MSK_CLR)
        |-> reg_rdata == '0);

    // R3: an accepted control write selecting input turns the driver off
    p_dir_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && hit_ctl && !pin_lock[pin_idx] && reg_wdata[0]
        |=> !pin_oe[$past(pin_idx)]);
endmodule

// File: tb/tb_gpio_bank_unit.sv
`timescale 1ns/1ps
module tb_gpio_bank_unit;
    localparam int NB = 8;
    localparam int NP = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          drv_we = 1'b0;
    logic [11:0]   drv_addr = '0;
    logic [31:0]   drv_wd = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] drv_pin = '0;
    logic [NP-1:0] drv_lock = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [NB-1:0] irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // reference state
    logic [NP-1:0] m_out, m_sts, m_msk, m_dir, m_prev;
    logic [1:0]    m_trig [NP];

    always #5 clk = ~clk;

    gpio_bank_unit #(.NUM_BANKS(NB), .ADDR_W(12)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (drv_we),
        .reg_addr  (drv_addr),
        .reg_wdata (drv_wd),
        .reg_rdata (rdata),
        .pin_in    (drv_pin),
        .pin_lock  (drv_lock),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .bank_irq  (irq)
    );

    task automatic chk(input logic [NP-1:0] act, input logic [NP-1:0] exp,
                       input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a, input logic [NP-1:0] pin);
        int b, p;
        if (a[1:0] != 2'b00) return '0;
        if (a < 12'h100) begin
            b = int'(a[4:2]);
            if (b >= NB) return '0;
            case (a[7:5])
                3'd0: return m_out[b*32 +: 32];
                3'd1: return pin[b*32 +: 32];
                3'd4: return m_sts[b*32 +: 32];
                3'd5: return m_msk[b*32 +: 32];
                default: return '0;
            endcase
        end
        if (int'(a) < 'h100 + 4 * NP) begin
            p = (int'(a) - 'h100) >> 2;
            return {27'b0, m_trig[p], 2'b00, m_dir[p]};
        end
        return '0;
    endfunction

    function automatic string auto_tag(input logic [11:0] a);
        if (a[1:0] != 2'b00 || int'(a) >= 'h100 + 4 * NP) return "R11";
        if (a >= 12'h100) return "R3";
        case (a[7:5])
            3'd0: return "R2";
            3'd1: return "R4";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [NB-1:0] exp_irq();
        logic [NB-1:0] v;
        for (int b = 0; b < NB; b++) v[b] = |(m_sts[b*32 +: 32] & ~m_msk[b*32 +: 32]);
        return v;
    endfunction

    task automatic model_edge(input logic we, input logic [11:0] a, input logic [31:0] wd,
                              input logic [NP-1:0] pin, input logic [NP-1:0] lock);
        logic [NP-1:0] hit;
        int b, p, n;
        for (int k = 0; k < NP; k++) begin
            logic r, f;
            r = pin[k] & ~m_prev[k];
            f = ~pin[k] & m_prev[k];
            hit[k] = (m_trig[k][0] & r) | (m_trig[k][1] & f);
        end
        if (we && a[1:0] == 2'b00) begin
            if (a < 12'h100) begin
                b = int'(a[4:2]);
                if (b < NB) begin
                    for (int i = 0; i < 32; i++) begin
                        n = b * 32 + i;
                        if (wd[i]) begin
                            case (a[7:5])
                                3'd2: if (!lock[n]) m_out[n] = 1'b1;
                                3'd3: if (!lock[n]) m_out[n] = 1'b0;
                                3'd4: m_sts[n] = 1'b0;
                                3'd5: m_msk[n] = 1'b1;
                                3'd6: m_msk[n] = 1'b0;
                                default: ;
                            endcase
                        end
                    end
                end
            end else if (int'(a) < 'h100 + 4 * NP) begin
                p = (int'(a) - 'h100) >> 2;
                if (!lock[p]) begin
                    m_dir[p]  = wd[0];
                    m_trig[p] = wd[4:3];
                end
            end
        end
        m_sts  = m_sts | hit;
        m_prev = pin;
    endtask

    // one bus cycle: drive at falling edge, check, then advance the model at the rising edge
    task automatic tick(input logic we, input logic [11:0] a, input logic [31:0] wd,
                        input logic [NP-1:0] pin, input logic [NP-1:0] lock, input string tag);
        string t;
        @(negedge clk);
        drv_we = we; drv_addr = a; drv_wd = wd; drv_pin = pin; drv_lock = lock;
        #1;
        t = (tag == "") ? auto_tag(a) : tag;
        chk(NP'(rdata), NP'(exp_read(a, pin)), t, "rdata");
        chk(NP'(irq), NP'(exp_irq()), "R8", "bank_irq");
        chk(pin_out, m_out, "R2", "pin_out");
        chk(pin_oe, ~m_dir, "R3", "pin_oe");
        @(posedge clk);
        model_edge(we, a, wd, pin, lock);
    endtask

    function automatic logic [NP-1:0] sparse(input int ands);
        logic [NP-1:0] v;
        for (int w = 0; w < NB; w++) begin
            logic [31:0] x;
            x = $urandom;
            for (int k = 0; k < ands; k++) x = x & $urandom;
            v[w*32 +: 32] = x;
        end
        return v;
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] pin;
        logic [NP-1:0] lk;
        void'($urandom(32'd4242));
        m_out = '0; m_sts = '0; m_msk = '1; m_dir = '1; m_prev = '0;
        for (int k = 0; k < NP; k++) m_trig[k] = 2'b00;
        pin = '0; lk = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10: reset state through the bus
        tick(0, 12'h100, 0, pin, lk, "R10");
        tick(0, 12'h0A0, 0, pin, lk, "R10");
        tick(0, 12'h09C, 0, pin, lk, "R10");
        tick(0, 12'h01C, 0, pin, lk, "R10");

        // R2: set then clear outputs, make pin 4 an output
        tick(1, 12'h040, 32'h0000_00F0, pin, lk, "R2");
        tick(1, 12'h110, 32'h0, pin, lk, "R3");
        tick(1, 12'h060, 32'h0000_0030, pin, lk, "R2");
        tick(0, 12'h000, 0, pin, lk, "R2");

        // R1: pin 37 is bank 1 bit 5; rising trigger, unmask, raise it
        tick(1, 12'h194, 32'h09, pin, lk, "R1");
        tick(1, 12'h0C4, 32'h20, pin, lk, "R1");
        pin[37] = 1'b1;
        tick(0, 12'h084, 0, pin, lk, "R1");
        tick(0, 12'h084, 0, pin, lk, "R1");
        // R5: falling edge with rising trigger captures nothing after clear
        tick(1, 12'h084, 32'h20, pin, lk, "R6");
        pin[37] = 1'b0;
        tick(0, 12'h084, 0, pin, lk, "R5");
        tick(0, 12'h084, 0, pin, lk, "R5");
        // R6: both-edge trigger, edge coincides with a clear write
        tick(1, 12'h194, 32'h19, pin, lk, "R5");
        pin[37] = 1'b1;
        tick(1, 12'h084, 32'h20, pin, lk, "R6");
        tick(0, 12'h084, 0, pin, lk, "R6");
        // R7/R8: masking drops the line
        tick(1, 12'h0A4, 32'h20, pin, lk, "R7");
        tick(0, 12'h0A4, 0, pin, lk, "R8");
        // R9: locked pin 4 ignores clear and control writes
        lk[4] = 1'b1;
        tick(1, 12'h060, 32'h10, pin, lk, "R9");
        tick(1, 12'h110, 32'h19, pin, lk, "R9");
        tick(0, 12'h000, 0, pin, lk, "R9");
        tick(0, 12'h110, 0, pin, lk, "R9");
        lk = '0;
        // R4: input pattern read back in same cycle
        pin[95:64] = 32'hA5C3_0F18;
        tick(0, 12'h028, 0, pin, lk, "R4");
        // R11: unmapped and write-only reads, and an ignored write
        tick(0, 12'h0E0, 0, pin, lk, "R11");
        tick(1, 12'h500, 32'hFFFF_FFFF, pin, lk, "R11");
        tick(0, 12'h042, 0, pin, lk, "R11");
        tick(0, 12'h0C0, 0, pin, lk, "R11");

        // constrained random phase
        for (int c = 0; c < 2500; c++) begin
            logic [11:0] a;
            logic [31:0] wd;
            int sel;
            sel = $urandom_range(0, 9);
            if (sel <= 5) begin
                a = 12'($urandom_range(0, 7) * 32 + $urandom_range(0, 7) * 4);
                wd = $urandom & $urandom;
            end else if (sel <= 8) begin
                a = 12'('h100 + $urandom_range(0, NP - 1) * 4);
                wd = $urandom;
            end else begin
                a = 12'($urandom_range('h500, 'hFFF));
                wd = $urandom;
            end
            if (c % 50 == 0) lk = sparse(3);
            pin = pin ^ sparse(2);
            tick($urandom_range(0, 3) != 0, a, wd, pin, lk, "");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule